// File: doc/BRIEF.md
# SAR ADC serial readout controller

This block is the host-side master for a two-input, 12-bit successive-approximation converter with a three-wire serial link. It drives an active-low chip select, a serial clock and a channel-select line, and it shifts in the result bit stream. Each conversion becomes one 12-bit word, tagged with the input it came from and a framing-error bit, offered on a valid/ready output.

A frame opens when chip select falls, which is also the sampling instant. The serial clock idles high. Each clock cycle is a low half followed by a high half. The converter changes its data line on the falling edge, and the controller samples it on the following rising edge. A frame is 16 or 14 cycles long, selected per frame. The controller tracks the converter's power state itself. It puts the converter to sleep by raising chip select early in a frame. It wakes the converter with a full-length dummy frame whose data is discarded. Channel selection is pipelined by one frame: the channel programmed during one frame is the channel converted in the next. The controller either follows a requested channel or alternates between the two inputs.

The serial clock half-period, the minimum chip-select high time, the quiet time between frames and the cycle at which a sleep frame is cut short are all parameters. The serial clock half-period is counted in system clocks.

Top module: `sar_readout_ctrl`

## Requirements
- R1: After reset the controller holds chip select high, serial clock high, channel select low and output valid low. It reports the converter as asleep (lowPower = 1).
- R2: With shortMode low, a conversion or wake frame drives chip select low and issues exactly 16 serial clock falling edges. Chip select rises after the rising edge of cycle 16. The serial clock stays high whenever chip select is high.
- R3: The bit sampled on the rising edges of cycles 2 to 13 forms the result, MSB first. Cycle 2 carries bit 11 and cycle 13 carries bit 0. Each conversion frame run while the converter is awake yields exactly one result.
- R4: The channel-select line changes only while chip select is low, at the falling edge that starts cycle 3. The channel tag of a result is the channel-select value programmed during the previous frame (0 = input 1, 1 = input 2).
- R5: With altMode high, each frame programs the opposite of the channel it is converting, so consecutive results carry alternating tags. With altMode low, each frame programs reqChan.
- R6: With shortMode high when a frame opens, that frame issues exactly 14 falling edges.
- R7: When awake and idle, with sleepReq high, the controller runs a sleep frame. Chip select rises after ABORT_CYC falling edges (default 5, which lies between 3 and 9). lowPower is then set, and no result is produced.
- R8: A conversion request while asleep first runs one full-length dummy frame. That frame produces no result and clears lowPower. The next frame yields a valid result.
- R9: resErr is set on a result when the bit sampled in cycle 1, or in any of cycles 14 to 15 that the frame contains, is 1. Otherwise resErr is 0.
- R10: Between frames, chip select stays high for at least max(CS_HIGH_MIN, QUIET_MIN) system clocks.
- R11: While resValid is high and resReady is low, resValid, resData, resChan and resErr hold. A frame due to deliver a result keeps chip select low until the output slot frees.
- R12: While asleep, with convReq low, no frame is started, whatever the level of sleepReq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| convReq | input | 1 | Level request to run conversion frames |
| sleepReq | input | 1 | Level request to put the converter to sleep |
| shortMode | input | 1 | 1 selects 14-cycle frames, 0 selects 16-cycle frames |
| altMode | input | 1 | 1 alternates channels frame by frame |
| reqChan | input | 1 | Channel to program when altMode is 0 |
| csN | output | 1 | Active-low chip select to the converter |
| sclk | output | 1 | Serial clock to the converter, idle high |
| chSel | output | 1 | Channel-select line to the converter |
| sdata | input | 1 | Serial data from the converter |
| resValid | output | 1 | Result word valid |
| resReady | input | 1 | Result word accepted |
| resData | output | DATA_W | Conversion result |
| resChan | output | 1 | Channel the result came from |
| resErr | output | 1 | Leading or trailing bit was not zero |
| lowPower | output | 1 | Controller considers the converter asleep |

## Verification
The checks assume that the converter changes its data line only on serial clock falling edges. They also assume that shortMode is changed only while no frame is running, so the expected frame length is known at the time chip select rises. The stimulus drives the data line from a behavioural converter model that follows chip select and clock edges, and it toggles shortMode only after the request has dropped and the link has been idle for far longer than a frame. Ready is driven always high, toggling, or held low for long stretches, so the output-hold rule is exercised against results that are still in flight.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;

  parameter int CYC_W = 5;

  typedef enum logic [1:0] {
    KIND_CONV,
    KIND_WAKE,
    KIND_SLEEP
  } frame_kind_e;

  // strobes from control to datapath, valid for one system clock
  typedef struct packed {
    logic             open;        // chip select falls this edge
    logic             sample;      // serial clock rises this edge
    logic             chanSwitch;  // falling edge into the channel-switch cycle
    logic             publish;     // conversion frame ends with a result
    logic [CYC_W-1:0] cycIdx;      // current serial cycle number
  } rd_strobe_t;

endpackage

// File: rtl/sar_rd_ctrl.sv
module sar_rd_ctrl
  import sar_rd_pkg::*;
#(
  parameter int HALF_DIV  = 2,
  parameter int GAP_CYC   = 3,
  parameter int ABORT_CYC = 5,
  parameter int LONG_LEN  = 16,
  parameter int SHORT_LEN = 14,
  parameter int CHAN_CYC  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       convReq,
  input  logic       sleepReq,
  input  logic       shortMode,
  input  logic       outBusy,
  output logic       csN,
  output logic       sclk,
  output logic       lowPower,
  output rd_strobe_t strobe
);

  localparam int HW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int GW = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_GAP} st_e;

  st_e              state;
  frame_kind_e      kind;
  logic [HW-1:0]    halfCnt;
  logic [CYC_W-1:0] cycCnt;
  logic [CYC_W-1:0] frameLen;
  logic [GW-1:0]    gapCnt;

  logic phaseEnd;
  logic atLast;
  logic wantSleep;
  logic holdEnd;
  logic endNow;

  always_comb begin
    phaseEnd  = (halfCnt == HW'(HALF_DIV - 1));
    atLast    = (kind == KIND_SLEEP) ? (cycCnt == CYC_W'(ABORT_CYC))
                                     : (cycCnt == frameLen);
    wantSleep = !lowPower && sleepReq;
    holdEnd   = (kind == KIND_CONV) && outBusy;
    endNow    = (state == S_RUN) && phaseEnd && sclk && atLast && !holdEnd;

    strobe        = '0;
    strobe.cycIdx = cycCnt;
    if (state == S_IDLE && (wantSleep || convReq)) strobe.open = 1'b1;
    if (state == S_RUN && phaseEnd) begin
      if (!sclk) begin
        strobe.sample = 1'b1;
      end else if (!atLast) begin
        strobe.chanSwitch = (cycCnt == CYC_W'(CHAN_CYC - 1));
      end else if (kind == KIND_CONV && !outBusy) begin
        strobe.publish = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      kind     <= KIND_CONV;
      csN      <= 1'b1;
      sclk     <= 1'b1;
      halfCnt  <= '0;
      cycCnt   <= '0;
      frameLen <= CYC_W'(LONG_LEN);
      gapCnt   <= '0;
      lowPower <= 1'b1;
    end else begin
      case (state)
        S_IDLE: begin
          if (strobe.open) begin
            csN      <= 1'b0;
            halfCnt  <= '0;
            cycCnt   <= '0;
            frameLen <= shortMode ? CYC_W'(SHORT_LEN) : CYC_W'(LONG_LEN);
            if (wantSleep)     kind <= KIND_SLEEP;
            else if (lowPower) kind <= KIND_WAKE;
            else               kind <= KIND_CONV;
            state    <= S_RUN;
          end
        end
        S_RUN: begin
          if (!phaseEnd) begin
            halfCnt <= halfCnt + 1'b1;
          end else if (!sclk) begin
            sclk    <= 1'b1;
            halfCnt <= '0;
          end else if (!atLast) begin
            sclk    <= 1'b0;
            halfCnt <= '0;
            cycCnt  <= cycCnt + 1'b1;
          end else if (endNow) begin
            csN    <= 1'b1;
            gapCnt <= '0;
            state  <= S_GAP;
            if (kind == KIND_SLEEP)     lowPower <= 1'b1;
            else if (kind == KIND_WAKE) lowPower <= 1'b0;
          end
        end
        S_GAP: begin
          if (gapCnt == GW'(GAP_CYC - 1)) state <= S_IDLE;
          else                            gapCnt <= gapCnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sar_rd_dp.sv
module sar_rd_dp
  import sar_rd_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int LONG_LEN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rd_strobe_t        strobe,
  input  logic              sdata,
  input  logic              altMode,
  input  logic              reqChan,
  input  logic              resReady,
  output logic              chSel,
  output logic              resValid,
  output logic [DATA_W-1:0] resData,
  output logic              resChan,
  output logic              resErr,
  output logic              outBusy
);

  localparam int LEAD_CYC   = 1;
  localparam int FIRST_DATA = LEAD_CYC + 1;
  localparam int LAST_DATA  = LEAD_CYC + DATA_W;
  localparam int LAST_CHECK = LONG_LEN - 1;   // final cycle may be high impedance

  logic [DATA_W-1:0] shiftReg;
  logic              errAcc;
  logic              tagChan;
  logic              targetChan;
  int                idx;

  assign idx     = int'(strobe.cycIdx);
  assign outBusy = resValid && !resReady;

  // capture and framing check
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftReg   <= '0;
      errAcc     <= 1'b0;
      tagChan    <= 1'b0;
      targetChan <= 1'b0;
    end else if (strobe.open) begin
      shiftReg   <= '0;
      errAcc     <= 1'b0;
      tagChan    <= chSel;
      targetChan <= altMode ? !chSel : reqChan;
    end else if (strobe.sample) begin
      if (idx == LEAD_CYC) begin
        errAcc <= errAcc | sdata;
      end else if (idx >= FIRST_DATA && idx <= LAST_DATA) begin
        shiftReg <= {shiftReg[DATA_W-2:0], sdata};
      end else if (idx > LAST_DATA && idx <= LAST_CHECK) begin
        errAcc <= errAcc | sdata;
      end
    end
  end

  // channel line, programmed for the following frame
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 chSel <= 1'b0;
    else if (strobe.chanSwitch) chSel <= targetChan;
  end

  // result slot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resValid <= 1'b0;
      resData  <= '0;
      resChan  <= 1'b0;
      resErr   <= 1'b0;
    end else if (strobe.publish) begin
      resValid <= 1'b1;
      resData  <= shiftReg;
      resChan  <= tagChan;
      resErr   <= errAcc;
    end else if (resReady) begin
      resValid <= 1'b0;
    end
  end

endmodule

// File: rtl/sar_readout_ctrl.sv
module sar_readout_ctrl
  import sar_rd_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int HALF_DIV    = 2,
  parameter int CS_HIGH_MIN = 2,
  parameter int QUIET_MIN   = 3,
  parameter int ABORT_CYC   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              convReq,
  input  logic              sleepReq,
  input  logic              shortMode,
  input  logic              altMode,
  input  logic              reqChan,
  output logic              csN,
  output logic              sclk,
  output logic              chSel,
  input  logic              sdata,
  output logic              resValid,
  input  logic              resReady,
  output logic [DATA_W-1:0] resData,
  output logic              resChan,
  output logic              resErr,
  output logic              lowPower
);

  localparam int LONG_LEN  = DATA_W + 4;
  localparam int SHORT_LEN = DATA_W + 2;
  localparam int GAP_CYC   = (CS_HIGH_MIN > QUIET_MIN) ? CS_HIGH_MIN : QUIET_MIN;
  localparam int CHAN_CYC  = 3;

  rd_strobe_t strobe;
  logic       outBusy;

  sar_rd_ctrl #(
    .HALF_DIV (HALF_DIV),
    .GAP_CYC  (GAP_CYC),
    .ABORT_CYC(ABORT_CYC),
    .LONG_LEN (LONG_LEN),
    .SHORT_LEN(SHORT_LEN),
    .CHAN_CYC (CHAN_CYC)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .convReq  (convReq),
    .sleepReq (sleepReq),
    .shortMode(shortMode),
    .outBusy  (outBusy),
    .csN      (csN),
    .sclk     (sclk),
    .lowPower (lowPower),
    .strobe   (strobe)
  );

  sar_rd_dp #(
    .DATA_W  (DATA_W),
    .LONG_LEN(LONG_LEN)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .sdata   (sdata),
    .altMode (altMode),
    .reqChan (reqChan),
    .resReady(resReady),
    .chSel   (chSel),
    .resValid(resValid),
    .resData (resData),
    .resChan (resChan),
    .resErr  (resErr),
    .outBusy (outBusy)
  );

endmodule

// File: rtl/sar_readout_ctrl_chk.sv
module sar_readout_ctrl_chk #(
  parameter int DATA_W      = 12,
  parameter int CS_HIGH_MIN = 2,
  parameter int QUIET_MIN   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              csN,
  input logic              sclk,
  input logic              chSel,
  input logic              resValid,
  input logic              resReady,
  input logic [DATA_W-1:0] resData,
  input logic              resChan,
  input logic              resErr,
  input logic              lowPower
);

  localparam int GAP_CYC = (CS_HIGH_MIN > QUIET_MIN) ? CS_HIGH_MIN : QUIET_MIN;

  logic [7:0] highCnt;
  logic [7:0] fallCnt;
  logic       sclkQ;
  logic       seenRise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      highCnt  <= '0;
      fallCnt  <= '0;
      sclkQ    <= 1'b1;
      seenRise <= 1'b0;
    end else begin
      sclkQ <= sclk;
      if (csN) highCnt <= (highCnt != 8'hFF) ? highCnt + 8'd1 : highCnt;
      else     highCnt <= '0;
      if (csN)                fallCnt <= '0;
      else if (sclkQ && !sclk) fallCnt <= fallCnt + 8'd1;
      if ($rose(csN)) seenRise <= 1'b1;
    end
  end

  // R2: clock idles high outside a frame
  p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    csN |-> sclk);

  // R2: a frame that leaves the converter awake runs at least ten falling edges
  p_full_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(csN) && !lowPower) |-> (fallCnt >= 8'd10));

  // R7: entering sleep only by an early chip-select rise
  p_sleep_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lowPower) |-> ($rose(csN) && fallCnt > 8'd2 && fallCnt < 8'd10));

  // R4: channel line moves only inside a frame, within the allowed window
  p_chan_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chSel) |-> (!csN && fallCnt >= 8'd2 && fallCnt <= 8'd11));

  // R10: minimum high time between frames
  p_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(csN) && seenRise) |-> (highCnt >= 8'(GAP_CYC)));

  // R11: a stalled result holds
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (resValid && !resReady) |=>
      (resValid && $stable(resData) && $stable(resChan) && $stable(resErr)));

endmodule

bind sar_readout_ctrl sar_readout_ctrl_chk #(
  .DATA_W     (DATA_W),
  .CS_HIGH_MIN(CS_HIGH_MIN),
  .QUIET_MIN  (QUIET_MIN)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .csN     (csN),
  .sclk    (sclk),
  .chSel   (chSel),
  .resValid(resValid),
  .resReady(resReady),
  .resData (resData),
  .resChan (resChan),
  .resErr  (resErr),
  .lowPower(lowPower)
);

// File: tb/sar_readout_ctrl_tb.sv
module sar_readout_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 12;
  localparam int ABORT_CYC  = 5;
  localparam int GAP_MIN    = 3;
  localparam int WATCHDOG   = 150000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              convReq = 1'b0, sleepReq = 1'b0, shortMode = 1'b0;
  logic              altMode = 1'b0, reqChan = 1'b0;
  logic              csN, sclk, chSel;
  logic              sdata = 1'b0;
  logic              resValid, resChan, resErr, lowPower;
  logic              resReady = 1'b1;
  logic [DATA_W-1:0] resData;

  sar_readout_ctrl #(.DATA_W(DATA_W), .HALF_DIV(2), .CS_HIGH_MIN(2),
                     .QUIET_MIN(GAP_MIN), .ABORT_CYC(ABORT_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .convReq(convReq), .sleepReq(sleepReq),
    .shortMode(shortMode), .altMode(altMode), .reqChan(reqChan),
    .csN(csN), .sclk(sclk), .chSel(chSel), .sdata(sdata),
    .resValid(resValid), .resReady(resReady), .resData(resData),
    .resChan(resChan), .resErr(resErr), .lowPower(lowPower));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // behavioural converter and result model
  bit        prevCs = 1'b1, prevSclk = 1'b1, prevCh = 1'b0;
  int        falls = 0, frameNo = 0, highCnt = 0, csFalls = 0, wakes = 0;
  bit        seenRise = 1'b0, devAwake = 1'b0, devChan = 1'b0, pendChan = 1'b0;
  bit        injLead = 1'b0, injTrail = 1'b0, curLead = 1'b0, curTrail = 1'b0;
  logic [DATA_W-1:0] curCode = '0;
  logic [DATA_W+1:0] expQ[$];
  int        readyMode = 0, pops = 0, errSeen = 0;
  bit        altCheck = 1'b0, havePrevTag = 1'b0, prevTag = 1'b0;
  bit        holdPend = 1'b0;
  logic [DATA_W+1:0] holdVal = '0;

  function automatic logic [DATA_W-1:0] codeFor(input int n);
    case (n % 4)
      0:       codeFor = '1;
      1:       codeFor = '0;
      default: codeFor = DATA_W'((n * 1709 + 83) % 4096);
    endcase
  endfunction

  function automatic logic streamBit(input int k);
    if (k == 1)                 streamBit = curLead;
    else if (k >= 2 && k <= 13) streamBit = curCode[13-k];
    else if (k == 14)           streamBit = curTrail;
    else                        streamBit = 1'b0;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      cyc++;
      if (prevCs && !csN) begin
        if (seenRise) chk(highCnt >= GAP_MIN, "R10", "chip-select high clocks", highCnt, GAP_MIN);
        csFalls++;
        falls    = 0;
        curCode  = codeFor(frameNo);
        frameNo++;
        curLead  = injLead;
        curTrail = injTrail;
        injLead  = 1'b0;
        injTrail = 1'b0;
        sdata    = 1'b0;
      end
      if (!csN && prevSclk && !sclk) begin
        falls++;
        sdata = streamBit(falls);
      end
      if (chSel != prevCh) begin
        chk(!csN && falls >= 2 && falls <= 12, "R4", "channel change at falling edge", falls, 3);
        pendChan = chSel;
      end
      if (!prevCs && csN) begin
        seenRise = 1'b1;
        if (falls >= 10) begin
          chk(falls == (shortMode ? 14 : 16), shortMode ? "R6" : "R2", "falling edges in frame",
              falls, shortMode ? 14 : 16);
          if (devAwake) begin
            expQ.push_back({curLead | curTrail, devChan, curCode});
          end else begin
            wakes++;
            devAwake = 1'b1;
          end
          chk(lowPower == 1'b0, "R8", "lowPower after full frame", lowPower, 0);
        end else begin
          chk(falls == ABORT_CYC, "R7", "falling edges in sleep frame", falls, ABORT_CYC);
          devAwake = 1'b0;
          chk(lowPower == 1'b1, "R7", "lowPower after sleep frame", lowPower, 1);
        end
        devChan = pendChan;
        sdata   = 1'b0;
      end
      if (csN) highCnt++;
      else     highCnt = 0;

      // consumer
      if (holdPend) begin
        chk(resValid && {resErr, resChan, resData} == holdVal, "R11", "stalled result held",
            int'({resErr, resChan, resData}), int'(holdVal));
        holdPend = 1'b0;
      end
      case (readyMode)
        0:       resReady = 1'b1;
        1:       resReady = (cyc % 3) != 0;
        default: resReady = 1'b0;
      endcase
      if (resValid && !resReady) begin
        holdPend = 1'b1;
        holdVal  = {resErr, resChan, resData};
      end
      if (resValid && resReady) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R3", "unexpected result", int'(resData), -1);
        end else begin
          logic [DATA_W+1:0] e;
          e = expQ.pop_front();
          chk(resData == e[DATA_W-1:0], "R3", "result data", int'(resData), int'(e[DATA_W-1:0]));
          chk(resChan == e[DATA_W], "R4", "result channel tag", int'(resChan), int'(e[DATA_W]));
          chk(resErr == e[DATA_W+1], "R9", "framing error flag", int'(resErr), int'(e[DATA_W+1]));
          if (resErr) errSeen++;
        end
        if (altCheck && havePrevTag)
          chk(resChan != prevTag, "R5", "alternating tag", int'(resChan), int'(!prevTag));
        prevTag     = resChan;
        havePrevTag = 1'b1;
        pops++;
      end
      prevCs   = csN;
      prevSclk = sclk;
      prevCh   = chSel;
    end
  end

  task automatic waitPops(input int n);
    int target;
    target = pops + n;
    while (pops < target) @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, WATCHDOG);
      report();
    end
  end

  initial begin
    int p0, f0, w0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(csN == 1'b1, "R1", "csN after reset", csN, 1);
    chk(sclk == 1'b1, "R1", "sclk after reset", sclk, 1);
    chk(chSel == 1'b0, "R1", "chSel after reset", chSel, 0);
    chk(resValid == 1'b0, "R1", "resValid after reset", resValid, 0);
    chk(lowPower == 1'b1, "R1", "lowPower after reset", lowPower, 1);

    // fixed channel, 16-cycle frames, wake from reset (R2 R3 R4 R8)
    reqChan = 1'b1;
    convReq = 1'b1;
    waitPops(4);
    chk(wakes == 1, "R8", "dummy frames after reset", wakes, 1);

    // alternating channels (R5)
    altMode = 1'b1;
    waitPops(2);
    altCheck = 1'b1;
    waitPops(4);
    altCheck = 1'b0;
    altMode  = 1'b0;

    // framing errors (R9)
    injLead = 1'b1;
    waitPops(3);
    injTrail = 1'b1;
    waitPops(3);
    chk(errSeen == 2, "R9", "results flagged", errSeen, 2);

    // back-pressure (R11)
    readyMode = 1;
    waitPops(4);
    readyMode = 2;
    repeat (150) @(negedge clk);
    readyMode = 0;
    waitPops(2);

    // 14-cycle frames (R6)
    convReq = 1'b0;
    repeat (300) @(negedge clk);
    shortMode = 1'b1;
    reqChan   = 1'b0;
    convReq   = 1'b1;
    waitPops(4);
    convReq = 1'b0;
    repeat (300) @(negedge clk);

    // sleep, stay asleep, wake (R7 R12 R8)
    sleepReq = 1'b1;
    repeat (200) @(negedge clk);
    chk(lowPower == 1'b1, "R7", "lowPower after sleep request", lowPower, 1);
    p0 = pops;
    f0 = csFalls;
    repeat (300) @(negedge clk);
    chk(csFalls == f0, "R12", "frames while asleep", csFalls, f0);
    chk(pops == p0, "R7", "results while asleep", pops, p0);
    sleepReq = 1'b0;
    w0 = wakes;
    convReq = 1'b1;
    waitPops(3);
    chk(wakes == w0 + 1, "R8", "dummy frames on wake", wakes, w0 + 1);
    convReq = 1'b0;
    repeat (300) @(negedge clk);

    chk(expQ.size() == 0, "R3", "results left undelivered", expQ.size(), 0);
    report();
  end

endmodule